// File: doc/BRIEF.md
# Single-Error-Correcting Parity Engine for NAND Chunks

This block protects 512-byte chunks on a NAND data path with a 24-bit parity code. The code corrects one bit error and detects two. Each chip select has its own accumulator. A start pulse for a chip select clears and arms its accumulator. Then, one byte per clock, the bytes tagged with that chip select fold into twelve "set" parities and twelve "clear" parities.

Every data bit has a 12-bit position, made of its byte address in the chunk and its bit index. Each position bit k has two parities. The "set" parity is the XOR of all data bits whose position has bit k at 1. The "clear" parity is the XOR of all data bits whose position has bit k at 0. A read request returns the whole code, inverted, for the selected chip select, and the same request empties that accumulator. Because the code is inverted, an erased chunk yields the same all-ones pattern that an erased spare area holds.

A separate judge stage takes the code stored with the data and a freshly computed code, and classifies their XOR in one registered cycle. The result is one of four kinds: clean, a fault in the stored code bytes only, a data bit to flip (with its byte and bit index), or uncorrectable. Applying the flip and storing the spare bytes are left to the surrounding logic.

Top module: `hecc_engine`

## Requirements
- R1: The code is ~{S, C}. S (code bits 23:12) holds the twelve "set" parities and C (code bits 11:0) the twelve "clear" parities. Position bit k is byte_address[k-3] for k of 3 to 11, and bit_index[k] for k of 0 to 2. Each accepted byte advances the byte address by one.
- R2: A full chunk of 512 bytes, all 0xFF, gives the code 0xFFFFFF.
- R3: A read request (rd_en) raises code_valid one cycle later, with the selected chip select's code on code_out. The same request clears and disarms that accumulator.
- R4: start[i] clears and arms accumulator i and restarts its byte address at 0, even in the middle of a chunk.
- R5: Bytes tagged for a disarmed chip select are ignored. Each chip select accumulates only the bytes tagged with its own index.
- R6: When stored_code equals calc_code, the result kind is 0 (clean).
- R7: When stored_code XOR calc_code has exactly one bit set, the kind is 1 (the code bytes are faulty and the data is good).
- R8: When the upper 12 bits of the difference XOR its lower 12 bits equal 0xFFF, the kind is 2. err_byte is difference bits 23:15 and err_bit is bits 14:12. If err_byte is not below CHUNK_BYTES, the kind is 3 instead.
- R9: Every other nonzero difference gives kind 3. uncorrectable is 1 exactly when a valid result has kind 3.
- R10: res_valid and the result follow cmp_valid by exactly one cycle.
- R11: In the cycle after reset, code_valid and res_valid are 0 and every accumulator is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_idx | input | CS_W | Chip select that the byte or the read applies to |
| start | input | NUM_CS | Per-chip-select clear-and-arm pulse |
| data_valid | input | 1 | A data byte is present |
| data_byte | input | 8 | Data byte |
| rd_en | input | 1 | Read the code of cs_idx and clear its accumulator |
| code_valid | output | 1 | code_out holds a read result |
| code_out | output | 24 | Inverted parity code |
| cmp_valid | input | 1 | Compare request |
| stored_code | input | 24 | Code read back from the spare area |
| calc_code | input | 24 | Code computed over the data read back |
| res_valid | output | 1 | A result is present |
| res_kind | output | 2 | 0 clean, 1 code fault, 2 data fix, 3 uncorrectable |
| err_byte | output | 9 | Byte index of the bit to flip |
| err_bit | output | 3 | Bit index of the bit to flip |
| uncorrectable | output | 1 | Valid result of kind 3 |

## Verification
The assertions check on every cycle the timing of the read and compare paths. They also check that equal and one-bit-apart codes get the right kind, that a data fix never points past the chunk, and that the uncorrectable flag agrees with the kind. Only the bench's scenarios can show that the accumulated code has the right value. Those scenarios cover:
- erased, patterned and single-bit-flipped chunks,
- restart in the middle of a chunk,
- bytes sent to a disarmed chip select,
- separation between chip selects,
- end-to-end correction, where a code computed over corrupted data locates the flipped bit.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = 3;
    localparam int ADDR_W    = 9;
    localparam int POS_W     = ADDR_W + BIT_IDX_W;
    localparam int CODE_W    = 2 * POS_W;

    typedef enum logic [1:0] {
        HK_CLEAN    = 2'd0,
        HK_CODE_HIT = 2'd1,
        HK_DATA_FIX = 2'd2,
        HK_FATAL    = 2'd3
    } hk_kind_e;

    typedef struct packed {
        logic [POS_W-1:0] set_par;
        logic [POS_W-1:0] clr_par;
    } parity_t;

    typedef struct packed {
        hk_kind_e               kind;
        logic [ADDR_W-1:0]      byte_idx;
        logic [BIT_IDX_W-1:0]   bit_idx;
    } verdict_t;

    // Parity contribution of one byte at a given chunk address.
    function automatic parity_t byte_contrib(input logic [ADDR_W-1:0] a,
                                             input logic [BYTE_W-1:0] d);
        parity_t r;
        logic    p;
        logic [BIT_IDX_W-1:0] bi;
        r = '0;
        p = ^d;
        for (int b = 0; b < BYTE_W; b++) begin
            bi = BIT_IDX_W'(b);
            for (int k = 0; k < BIT_IDX_W; k++) begin
                if (bi[k]) r.set_par[k] = r.set_par[k] ^ d[b];
                else       r.clr_par[k] = r.clr_par[k] ^ d[b];
            end
        end
        for (int j = 0; j < ADDR_W; j++) begin
            r.set_par[BIT_IDX_W+j] = a[j] & p;
            r.clr_par[BIT_IDX_W+j] = ~a[j] & p;
        end
        return r;
    endfunction

    function automatic logic [CODE_W-1:0] pack_code(input parity_t pr);
        return ~{pr.set_par, pr.clr_par};
    endfunction
endpackage

// File: rtl/hecc_lane.sv
module hecc_lane
    import hecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              clear,
    input  logic              feed,
    input  logic [BYTE_W-1:0] data_byte,
    output parity_t           par
);
    logic              armed;
    logic [ADDR_W-1:0] addr;
    parity_t           contrib;

    always_comb contrib = byte_contrib(addr, data_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            addr  <= '0;
            par   <= '0;
        end else if (start) begin
            armed <= 1'b1;
            addr  <= '0;
            par   <= '0;
        end else if (clear) begin
            armed <= 1'b0;
            addr  <= '0;
            par   <= '0;
        end else if (feed && armed) begin
            addr  <= addr + 1'b1;
            par   <= parity_t'(par ^ contrib);
        end
    end
endmodule

// File: rtl/hecc_judge.sv
module hecc_judge
    import hecc_pkg::*;
#(
    parameter int CHUNK_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_valid,
    input  logic [CODE_W-1:0] stored_code,
    input  logic [CODE_W-1:0] calc_code,
    output logic              res_valid,
    output verdict_t          verdict,
    output logic              fatal
);
    logic [CODE_W-1:0] diff;
    logic [POS_W-1:0]  fold;
    verdict_t          v_next;

    always_comb begin
        diff            = stored_code ^ calc_code;
        fold            = diff[CODE_W-1:POS_W] ^ diff[POS_W-1:0];
        v_next.byte_idx = diff[CODE_W-1:CODE_W-ADDR_W];
        v_next.bit_idx  = diff[POS_W+BIT_IDX_W-1:POS_W];
        if (diff == '0)
            v_next.kind = HK_CLEAN;
        else if (fold == {POS_W{1'b1}})
            v_next.kind = (int'(v_next.byte_idx) < CHUNK_BYTES) ? HK_DATA_FIX : HK_FATAL;
        else if ((diff & (diff - 1'b1)) == '0)
            v_next.kind = HK_CODE_HIT;
        else
            v_next.kind = HK_FATAL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            verdict   <= '0;
            fatal     <= 1'b0;
        end else begin
            res_valid <= cmp_valid;
            if (cmp_valid) verdict <= v_next;
            fatal     <= cmp_valid && (v_next.kind == HK_FATAL);
        end
    end
endmodule

// File: rtl/hecc_engine.sv
module hecc_engine
    import hecc_pkg::*;
#(
    parameter int NUM_CS      = 4,
    parameter int CHUNK_BYTES = 512,
    localparam int CS_W       = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CS_W-1:0]   cs_idx,
    input  logic [NUM_CS-1:0] start,
    input  logic              data_valid,
    input  logic [7:0]        data_byte,
    input  logic              rd_en,
    output logic              code_valid,
    output logic [23:0]       code_out,
    input  logic              cmp_valid,
    input  logic [23:0]       stored_code,
    input  logic [23:0]       calc_code,
    output logic              res_valid,
    output logic [1:0]        res_kind,
    output logic [8:0]        err_byte,
    output logic [2:0]        err_bit,
    output logic              uncorrectable
);
    parity_t  lane_par [NUM_CS];
    verdict_t verdict;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_lane
        logic hit;
        assign hit = (int'(cs_idx) == g);
        hecc_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .start     (start[g]),
            .clear     (rd_en && hit),
            .feed      (data_valid && hit),
            .data_byte (data_byte),
            .par       (lane_par[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_valid <= 1'b0;
            code_out   <= '0;
        end else begin
            code_valid <= rd_en;
            if (rd_en) code_out <= pack_code(lane_par[cs_idx]);
        end
    end

    hecc_judge #(.CHUNK_BYTES(CHUNK_BYTES)) u_judge (
        .clk         (clk),
        .rst         (rst),
        .cmp_valid   (cmp_valid),
        .stored_code (stored_code),
        .calc_code   (calc_code),
        .res_valid   (res_valid),
        .verdict     (verdict),
        .fatal       (uncorrectable)
    );

    assign res_kind = verdict.kind;
    assign err_byte = verdict.byte_idx;
    assign err_bit  = verdict.bit_idx;
endmodule

// File: rtl/hecc_engine_chk.sv
module hecc_engine_chk #(
    parameter int CHUNK_BYTES = 512
) (
    input logic        clk,
    input logic        rst,
    input logic        rd_en,
    input logic        code_valid,
    input logic        cmp_valid,
    input logic [23:0] stored_code,
    input logic [23:0] calc_code,
    input logic        res_valid,
    input logic [1:0]  res_kind,
    input logic [8:0]  err_byte,
    input logic        uncorrectable
);
    assert_read_latency_R3: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> code_valid);
    assert_read_origin_R3: assert property (@(posedge clk) disable iff (rst)
        code_valid |-> $past(rd_en));
    assert_result_follows_R10: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |=> res_valid);
    assert_result_origin_R10: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(cmp_valid));
    assert_equal_clean_R6: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && stored_code == calc_code) |=> res_kind == 2'd0);
    assert_one_bit_code_R7: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && $countones(stored_code ^ calc_code) == 1) |=> res_kind == 2'd1);
    assert_fix_in_chunk_R8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind == 2'd2) |-> int'(err_byte) < CHUNK_BYTES);
    assert_fatal_flag_R9: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (uncorrectable == (res_kind == 2'd3)));
    assert_reset_quiet_R11: assert property (@(posedge clk)
        rst |=> (!code_valid && !res_valid));
endmodule

bind hecc_engine hecc_engine_chk #(.CHUNK_BYTES(CHUNK_BYTES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rd_en         (rd_en),
    .code_valid    (code_valid),
    .cmp_valid     (cmp_valid),
    .stored_code   (stored_code),
    .calc_code     (calc_code),
    .res_valid     (res_valid),
    .res_kind      (res_kind),
    .err_byte      (err_byte),
    .uncorrectable (uncorrectable)
);

// File: tb/hecc_engine_bench.sv
module hecc_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cs_idx = '0;
    logic [3:0]  start = '0;
    logic        data_valid = 1'b0;
    logic [7:0]  data_byte = '0;
    logic        rd_en = 1'b0;
    logic        code_valid;
    logic [23:0] code_out;
    logic        cmp_valid = 1'b0;
    logic [23:0] stored_code = '0;
    logic [23:0] calc_code = '0;
    logic        res_valid;
    logic [1:0]  res_kind;
    logic [8:0]  err_byte;
    logic [2:0]  err_bit;
    logic        uncorrectable;

    logic        s_cmp_valid = 1'b0;
    logic [23:0] s_stored = '0;
    logic [23:0] s_calc = '0;
    logic        s_code_valid, s_res_valid, s_unc;
    logic [23:0] s_code_out;
    logic [1:0]  s_kind;
    logic [8:0]  s_byte;
    logic [2:0]  s_bit;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    hecc_engine u_hecc_engine (
        .clk(clk), .rst(rst), .cs_idx(cs_idx), .start(start),
        .data_valid(data_valid), .data_byte(data_byte), .rd_en(rd_en),
        .code_valid(code_valid), .code_out(code_out), .cmp_valid(cmp_valid),
        .stored_code(stored_code), .calc_code(calc_code), .res_valid(res_valid),
        .res_kind(res_kind), .err_byte(err_byte), .err_bit(err_bit),
        .uncorrectable(uncorrectable));

    hecc_engine #(.CHUNK_BYTES(320)) u_hecc_engine_small (
        .clk(clk), .rst(rst), .cs_idx(2'd0), .start(4'd0),
        .data_valid(1'b0), .data_byte(8'd0), .rd_en(1'b0),
        .code_valid(s_code_valid), .code_out(s_code_out), .cmp_valid(s_cmp_valid),
        .stored_code(s_stored), .calc_code(s_calc), .res_valid(s_res_valid),
        .res_kind(s_kind), .err_byte(s_byte), .err_bit(s_bit),
        .uncorrectable(s_unc));

    // stored, calc, kind, byte, bit
    localparam logic [61:0] VECS [8] = '{
        {24'h123456, 24'h123456, 2'd0, 9'd0,   3'd0},
        {24'h5A5A5A, 24'h5A525A, 2'd1, 9'd0,   3'd0},
        {24'h000000, 24'h800000, 2'd1, 9'd0,   3'd0},
        {24'hFFFFFF, 24'hFD402B, 2'd2, 9'd5,   3'd3},
        {24'h000000, 24'hFFF000, 2'd2, 9'd511, 3'd7},
        {24'hABCDEF, 24'hABC210, 2'd2, 9'd0,   3'd0},
        {24'h000000, 24'h000003, 2'd3, 9'd0,   3'd0},
        {24'h000000, 24'h800001, 2'd3, 9'd0,   3'd0}
    };

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) ^ (a >> 3));
    endfunction

    // mode 0: erased bytes, mode 1: pattern; fbyte < 0 means no flip
    function automatic logic [23:0] ref_code(input int mode, input int fbyte, input int fbit);
        logic [11:0] o, e;
        logic [7:0]  d;
        int          pos;
        o = '0; e = '0;
        for (int a = 0; a < 512; a++) begin
            d = (mode == 0) ? 8'hFF : pat(a);
            if (a == fbyte) d[fbit] = ~d[fbit];
            for (int b = 0; b < 8; b++) begin
                if (d[b]) begin
                    pos = a * 8 + b;
                    for (int k = 0; k < 12; k++) begin
                        if (pos[k]) o[k] = ~o[k];
                        else        e[k] = ~e[k];
                    end
                end
            end
        end
        return ~{o, e};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input int cs);
        @(negedge clk); start = 4'(1 << cs);
        @(negedge clk); start = '0;
    endtask

    task automatic stream(input int cs, input int mode, input int fbyte, input int fbit, input int n);
        logic [7:0] d;
        for (int a = 0; a < n; a++) begin
            @(negedge clk);
            d = (mode == 0) ? 8'hFF : pat(a);
            if (a == fbyte) d[fbit] = ~d[fbit];
            cs_idx = 2'(cs); data_valid = 1'b1; data_byte = d;
        end
        @(negedge clk); data_valid = 1'b0;
    endtask

    task automatic read_code(input int cs, output logic [23:0] c, output logic v);
        @(negedge clk); cs_idx = 2'(cs); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        c = code_out; v = code_valid;
    endtask

    task automatic compare(input logic [23:0] st, input logic [23:0] ca);
        @(negedge clk); cmp_valid = 1'b1; stored_code = st; calc_code = ca;
        @(negedge clk); cmp_valid = 1'b0;
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk); cycles++;
        end
        errors++;
        $display("FAIL watchdog actual %0d expected below %0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] c, good, bad;
        logic        v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 code_valid after reset", 32'(code_valid), 0);
        check("R11 res_valid after reset", 32'(res_valid), 0);
        // R11: accumulators disarmed, so bytes sent now leave the empty code
        stream(2, 1, -1, 0, 20);
        read_code(2, c, v);
        check("R11 disarmed after reset", 32'(c), 32'hFFFFFF);

        // compare vectors: R6 R7 R8 R9 R10
        for (int i = 0; i < 8; i++) begin
            compare(VECS[i][61:38], VECS[i][37:14]);
            check("R10 res_valid", 32'(res_valid), 1);
            check("R6/R7/R8/R9 kind", 32'(res_kind), 32'(VECS[i][13:12]));
            check("R9 uncorrectable flag", 32'(uncorrectable), 32'(VECS[i][13:12] == 2'd3));
            if (VECS[i][13:12] == 2'd2) begin
                check("R8 err_byte", 32'(err_byte), 32'(VECS[i][11:3]));
                check("R8 err_bit", 32'(err_bit), 32'(VECS[i][2:0]));
            end
        end
        @(negedge clk);
        check("R10 res_valid drops", 32'(res_valid), 0);

        // R8: index past a 320-byte chunk is uncorrectable, inside it is fixable
        @(negedge clk); s_cmp_valid = 1'b1; s_stored = 24'h000000; s_calc = 24'hC8237D;
        @(negedge clk); s_cmp_valid = 1'b0;
        check("R8 out-of-chunk index kind", 32'(s_kind), 3);
        check("R8 out-of-chunk uncorrectable", 32'(s_unc), 1);
        @(negedge clk); s_cmp_valid = 1'b1; s_calc = 24'h96169E;
        @(negedge clk); s_cmp_valid = 1'b0;
        check("R8 in-chunk kind", 32'(s_kind), 2);
        check("R8 in-chunk byte", 32'(s_byte), 300);
        check("R8 in-chunk bit", 32'(s_bit), 1);

        // R2: erased chunk
        pulse_start(0);
        stream(0, 0, -1, 0, 512);
        read_code(0, c, v);
        check("R3 code_valid", 32'(v), 1);
        check("R2 erased code", 32'(c), 32'hFFFFFF);
        @(negedge clk);
        check("R3 code_valid one cycle", 32'(code_valid), 0);

        // R1: patterned chunk
        good = ref_code(1, -1, 0);
        pulse_start(0);
        stream(0, 1, -1, 0, 512);
        read_code(0, c, v);
        check("R1 pattern code", 32'(c), 32'(good));

        // R3: read cleared and disarmed the lane
        stream(0, 1, -1, 0, 16);
        read_code(0, c, v);
        check("R3 cleared after read", 32'(c), 32'hFFFFFF);

        // R4: restart mid-chunk
        pulse_start(1);
        stream(1, 0, -1, 0, 100);
        pulse_start(1);
        stream(1, 1, -1, 0, 512);
        read_code(1, c, v);
        check("R4 restart mid-chunk", 32'(c), 32'(good));

        // R5: lanes independent; lane 3 never started
        pulse_start(2);
        stream(3, 1, -1, 0, 64);
        stream(2, 1, -1, 0, 512);
        read_code(3, c, v);
        check("R5 unstarted lane ignores bytes", 32'(c), 32'hFFFFFF);
        read_code(2, c, v);
        check("R5 lane 2 unaffected", 32'(c), 32'(good));

        // End to end: single flipped bit located (R1 R8)
        bad = ref_code(1, 77, 6);
        pulse_start(0);
        stream(0, 1, 77, 6, 512);
        read_code(0, c, v);
        check("R1 flipped chunk code", 32'(c), 32'(bad));
        compare(good, c);
        check("R8 end-to-end kind", 32'(res_kind), 2);
        check("R8 end-to-end byte", 32'(err_byte), 77);
        check("R8 end-to-end bit", 32'(err_bit), 6);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule